// File: doc/BRIEF.md
# Receiver Lock-Triggered Reset Sequencer

This block drives the active-low reset of an external digital audio receiver. That receiver can fall into a corrupted operating state when its input stream stops and then starts again. The block watches a power-good input and the receiver's active-low error flag. The flag reads high while the receiver is unlocked and low once it has locked onto a stream.

The first time the receiver locks after a stream loss, the sequencer holds the receiver in reset for a fixed, timed interval. It then releases the reset and lets the receiver relock. It does not react to that second lock, which the reset itself caused. The sequencer re-arms only when the error flag rises again, meaning the lock has been lost.

Both inputs are asynchronous to the block clock. Each passes through a two-flop synchronizer, and the error flag then goes through an edge detector. The pulse length comes from two parameters: the clock frequency in hertz and the pulse length in microseconds. The current state is visible on a 2-bit status output.

The machine has four states, plus a power-loss path that applies from any of them:

| State | Code | Reset output |
|---|---|---|
| OFF | 0 | asserted |
| ON | 1 | released |
| CLEAR | 2 | asserted |
| VALID | 3 | released |

| Transition | Condition |
|---|---|
| OFF to ON | power-good is high |
| ON to CLEAR | the error flag falls |
| CLEAR to VALID | the timer expires |
| VALID to ON | the error flag rises |
| any state to OFF | power-good is low |

Top module: `rx_relock_reset_seq`

## Requirements
- R1: After the asynchronous block reset, the state is OFF (status 0) and `rx_rst_n` is 0.
- R2: A low power-good input sends the machine to OFF from any state. `rx_rst_n` goes low two clock edges after the input falls, and the status reads OFF after the third edge.
- R3: In OFF with power-good high, the machine moves to ON on the third clock edge after power-good rises.
- R4: In ON, a falling edge of the error flag moves the machine to CLEAR on the third clock edge after the input falls. An error flag that is already low when ON is entered does not start a reset. While the flag stays high, the machine stays in ON.
- R5: CLEAR lasts exactly PULSE_CYCLES clock cycles and then moves to VALID. Edges of the error flag during CLEAR neither shorten nor extend this interval.
- R6: In VALID the machine stays put while the error flag is low. A rising edge of the flag returns it to ON.
- R7: `rx_rst_n` is 0 in OFF and CLEAR and whenever the synchronized power-good is low. It is 1 only in ON or VALID with power-good high.
- R8: `seq_state` encodes OFF=0, ON=1, CLEAR=2 and VALID=3.
- R9: PULSE_CYCLES equals (CLK_HZ/1000)*PULSE_US/1000, with a floor of 1. The defaults give 27033 cycles at 24.576 MHz, which is 1.1 ms and well above the receiver's 200 us minimum.
- R10: When power-good is seen low in the same cycle that the CLEAR timer expires, the machine goes to OFF and never enters VALID.
- R11: Edges of the error flag while in OFF have no effect. The machine stays in OFF until power-good returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low block reset (power-on) |
| pwr_good | input | 1 | Power-good indication, asynchronous, active high |
| rx_err_n | input | 1 | Receiver error/lock flag, asynchronous; low means locked |
| rx_rst_n | output | 1 | Active-low reset to the receiver |
| seq_state | output | 2 | Current state: 0 OFF, 1 ON, 2 CLEAR, 3 VALID |

## Verification
Two functions can land in the same cycle: the CLEAR timer reaching its last count, and the synchronized power-good dropping. The bench provokes this by driving power-good low exactly PULSE_CYCLES edges after it drives the error flag low. With three edges of latency on the lock path and two on the power path, both events then arrive in the final CLEAR cycle. The status is sampled on every following cycle. The check fails if VALID ever appears, and the machine must settle in OFF with the reset still held.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF   = 2'd0,
        SEQ_ON    = 2'd1,
        SEQ_CLEAR = 2'd2,
        SEQ_VALID = 2'd3
    } seq_state_e;

    // Reset pulse length in clock cycles, never below one.
    function automatic int unsigned pulse_cycles(input int unsigned clk_hz,
                                                 input int unsigned pulse_us);
        int unsigned c;
        c = ((clk_hz / 1000) * pulse_us) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/rrs_sync.sv
module rrs_sync #(
    parameter int unsigned     WIDTH     = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Each bit has its own two-flop chain with its own idle level.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic stab_q;

        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                meta_q <= RESET_VAL[i];
                stab_q <= RESET_VAL[i];
            end else begin
                meta_q <= d[i];
                stab_q <= meta_q;
            end
        end

        assign q[i] = stab_q;
    end

endmodule

// File: rtl/rrs_edge.sv
module rrs_edge #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic rise,
    output logic fall
);

    logic prev_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) prev_q <= RESET_VAL;
        else         prev_q <= d;
    end

    // Each edge yields a pulse lasting one cycle.
    assign rise = d & ~prev_q;
    assign fall = ~d & prev_q;

endmodule

// File: rtl/rrs_timer.sv
module rrs_timer #(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic run,
    output logic done
);

    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Held at zero outside the timed state, so each entry starts afresh.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)           cnt_q <= '0;
        else if (!run)         cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LAST);

endmodule

// File: rtl/rx_relock_reset_seq.sv
module rx_relock_reset_seq
    import rrs_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 24_576_000,
    parameter int unsigned PULSE_US = 1100
) (
    input  logic       clk,
    input  logic       arst_n,
    input  logic       pwr_good,
    input  logic       rx_err_n,
    output logic       rx_rst_n,
    output logic [1:0] seq_state
);

    localparam int unsigned PULSE_CYCLES = pulse_cycles(CLK_HZ, PULSE_US);

    // Bit 1 is the error flag, idling high (unlocked); bit 0 is power-good, idling low.
    localparam logic [1:0] SYNC_IDLE = 2'b10;

    logic [1:0] sync_q;
    logic       pg_s;
    logic       err_s;
    logic       err_rise;
    logic       err_fall;
    logic       tmr_done;
    seq_state_e state_q;
    seq_state_e state_d;

    rrs_sync #(.WIDTH(2), .RESET_VAL(SYNC_IDLE)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d      ({rx_err_n, pwr_good}),
        .q      (sync_q)
    );

    assign pg_s  = sync_q[0];
    assign err_s = sync_q[1];

    rrs_edge #(.RESET_VAL(1'b1)) u_err_edge (
        .clk    (clk),
        .arst_n (arst_n),
        .d      (err_s),
        .rise   (err_rise),
        .fall   (err_fall)
    );

    rrs_timer #(.CYCLES(PULSE_CYCLES)) u_timer (
        .clk    (clk),
        .arst_n (arst_n),
        .run    (state_q == SEQ_CLEAR),
        .done   (tmr_done)
    );

    // Next-state logic; loss of power overrides every other transition.
    always_comb begin
        state_d = state_q;
        if (!pg_s) begin
            state_d = SEQ_OFF;
        end else begin
            unique case (state_q)
                SEQ_OFF:   state_d = SEQ_ON;
                SEQ_ON:    if (err_fall) state_d = SEQ_CLEAR;
                SEQ_CLEAR: if (tmr_done) state_d = SEQ_VALID;
                SEQ_VALID: if (err_rise) state_d = SEQ_ON;
                default:   state_d = SEQ_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= SEQ_OFF;
        else         state_q <= state_d;
    end

    // Outputs: reset is released only in the two run states while power holds.
    always_comb begin
        seq_state = state_q;
        unique case (state_q)
            SEQ_ON, SEQ_VALID: rx_rst_n = pg_s;
            default:           rx_rst_n = 1'b0;
        endcase
    end

endmodule

// File: rtl/rx_relock_reset_seq_chk.sv
module rx_relock_reset_seq_chk #(
    parameter int unsigned PULSE_CYCLES = 1
) (
    input logic       clk,
    input logic       arst_n,
    input logic       pg_s,
    input logic [1:0] st,
    input logic       rx_rst_n
);

    int unsigned clear_run;

    // Counts cycles spent in CLEAR, so the pulse window is checked without deep $past.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)         clear_run <= 0;
        else if (st == 2'd2) clear_run <= clear_run + 1;
        else                 clear_run <= 0;
    end

    // R7: reset is held in OFF and CLEAR
    a_r7_reset_held: assert property (@(posedge clk) disable iff (!arst_n)
        (st == 2'd0 || st == 2'd2) |-> !rx_rst_n);

    // R2: synchronized power loss leads to OFF one edge later
    a_r2_power_loss_off: assert property (@(posedge clk) disable iff (!arst_n)
        !pg_s |=> (st == 2'd0));

    // R4: CLEAR is entered only from ON
    a_r4_clear_from_on: assert property (@(posedge clk) disable iff (!arst_n)
        (st == 2'd2 && $past(st) != 2'd2) |-> ($past(st) == 2'd1));

    // R5: VALID follows CLEAR after exactly PULSE_CYCLES cycles
    a_r5_pulse_length: assert property (@(posedge clk) disable iff (!arst_n)
        (st == 2'd3 && $past(st) == 2'd2) |-> (clear_run == PULSE_CYCLES));

    // R6: VALID is entered only from CLEAR or held
    a_r6_valid_source: assert property (@(posedge clk) disable iff (!arst_n)
        (st == 2'd3) |-> ($past(st) == 2'd2 || $past(st) == 2'd3));

    // R11: from OFF the only exit is ON
    a_r11_off_exit: assert property (@(posedge clk) disable iff (!arst_n)
        ($past(st) == 2'd0) |-> (st == 2'd0 || st == 2'd1));

endmodule

bind rx_relock_reset_seq rx_relock_reset_seq_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk      (clk),
    .arst_n   (arst_n),
    .pg_s     (pg_s),
    .st       (state_q),
    .rx_rst_n (rx_rst_n)
);

// File: tb/rx_relock_reset_seq_test.sv
module rx_relock_reset_seq_test;

    localparam time CLK_PERIOD = 10ns;
    localparam int unsigned T_CLK_HZ   = 10_000;
    localparam int unsigned T_PULSE_US = 1000;
    localparam int unsigned EXP_PULSE  = 10;   // R9: (10000/1000)*1000/1000
    localparam int NVEC = 15;

    // {pwr_good, rx_err_n, hold[4:0], expected state[1:0], expected rx_rst_n}
    localparam logic [9:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 5'd4,  2'd0, 1'b0},  // R1/R2 OFF without power
        {1'b1, 1'b1, 5'd4,  2'd1, 1'b1},  // R3 OFF to ON
        {1'b1, 1'b0, 5'd4,  2'd2, 1'b0},  // R4 lock starts CLEAR
        {1'b1, 1'b1, 5'd4,  2'd2, 1'b0},  // R5 lock lost during CLEAR, still CLEAR
        {1'b1, 1'b0, 5'd8,  2'd3, 1'b1},  // R5 relock ignored, timeout to VALID
        {1'b1, 1'b1, 5'd4,  2'd1, 1'b1},  // R6 lock lost re-arms
        {1'b1, 1'b0, 5'd4,  2'd2, 1'b0},  // R4 second lock resets again
        {1'b0, 1'b0, 5'd4,  2'd0, 1'b0},  // R2 power loss in CLEAR
        {1'b1, 1'b0, 5'd4,  2'd1, 1'b1},  // R4 flag already low: no reset
        {1'b1, 1'b1, 5'd4,  2'd1, 1'b1},  // R4 waits while flag high
        {1'b1, 1'b0, 5'd14, 2'd3, 1'b1},  // R5 full pulse then VALID
        {1'b0, 1'b0, 5'd4,  2'd0, 1'b0},  // R2 power loss in VALID
        {1'b0, 1'b1, 5'd4,  2'd0, 1'b0},  // R11 flag rise in OFF ignored
        {1'b0, 1'b0, 5'd4,  2'd0, 1'b0},  // R11 flag fall in OFF ignored
        {1'b1, 1'b0, 5'd4,  2'd1, 1'b1}   // R3 power back, no edge pending
    };

    string vtag [NVEC] = '{"R2", "R3", "R4", "R5", "R5", "R6", "R4", "R2",
                           "R4", "R4", "R5", "R2", "R11", "R11", "R3"};

    logic       clk = 1'b0;
    logic       arst_n = 1'b0;
    logic       pwr_good = 1'b0;
    logic       rx_err_n = 1'b1;
    logic       rx_rst_n;
    logic [1:0] seq_state;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    rx_relock_reset_seq #(.CLK_HZ(T_CLK_HZ), .PULSE_US(T_PULSE_US)) uut (
        .clk       (clk),
        .arst_n    (arst_n),
        .pwr_good  (pwr_good),
        .rx_err_n  (rx_err_n),
        .rx_rst_n  (rx_rst_n),
        .seq_state (seq_state)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic pg, input logic err, input int hold);
        @(negedge clk);
        pwr_good = pg;
        rx_err_n = err;
        repeat (hold) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        bit saw_valid;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 state after reset", seq_state, 0);
        chk("R1 rx_rst_n after reset", rx_rst_n, 0);
        arst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][9], VEC[i][8], int'(VEC[i][7:3]));
            chk({vtag[i], " state"}, seq_state, int'(VEC[i][2:1]));
            chk({vtag[i], " R7 rx_rst_n"}, rx_rst_n, int'(VEC[i][0]));
        end

        // R3 latency: ON exactly on the third edge after power returns
        drive(1'b0, 1'b1, 4);
        @(negedge clk);
        pwr_good = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R3 still OFF after two edges", seq_state, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R3 ON after third edge", seq_state, 1);

        // R5/R8/R9: measure the low time of rx_rst_n from a lock in ON
        drive(1'b1, 1'b1, 4);
        @(negedge clk);
        rx_err_n = 1'b0;
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (!rx_rst_n) cnt++;
            if (k == 3) chk("R8 CLEAR code", seq_state, 2);
        end
        chk("R5 R9 pulse length", cnt, EXP_PULSE);
        chk("R8 VALID code", seq_state, 3);

        // R10: power loss arrives in the last CLEAR cycle
        drive(1'b1, 1'b1, 4);
        chk("R6 re-armed before R10 case", seq_state, 1);
        @(negedge clk);
        rx_err_n = 1'b0;
        repeat (EXP_PULSE) @(posedge clk);
        @(negedge clk);
        pwr_good = 1'b0;
        saw_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (seq_state == 2'd3) saw_valid = 1'b1;
        end
        chk("R10 never VALID", saw_valid, 0);
        chk("R10 ends in OFF", seq_state, 0);
        chk("R10 reset held", rx_rst_n, 0);

        // R2 latency: from VALID, reset drops two edges after power loss
        drive(1'b1, 1'b0, 4);
        drive(1'b1, 1'b1, 4);
        drive(1'b1, 1'b0, 14);
        chk("R6 VALID holds while locked", seq_state, 3);
        @(negedge clk);
        pwr_good = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R2 rx_rst_n low after two edges", rx_rst_n, 0);
        chk("R2 state not yet OFF", seq_state, 3);
        @(posedge clk);
        @(negedge clk);
        chk("R2 OFF after third edge", seq_state, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule